// File: doc/BRIEF.md
# Supply supervisor serial configuration port

This block is the two-wire serial slave front end of a supply-supervisor chip. It does not see the bus pins. A separate synchroniser hands it single-cycle start, stop and bit events, each bit carrying the sampled data value. It answers with one open-drain request, `sda_low_o`, which asks the pad to pull the data line low. That request is used both for acknowledges and for read data. Every byte is framed as eight data clocks plus a ninth acknowledge clock. The acknowledge request is raised once the eighth bit has been taken and is held through the ninth clock.

Two kinds of transaction are understood. The first is the configuration register. Its slave byte carries the class nibble 1011 and the high address bit. A write to that register is guarded by two volatile enable latches, which are set by two separate preparatory writes. The third write then loads the five persistent fields, and the STOP after it raises a one-cycle commit pulse for the external persistent store. The second kind is the trip-threshold reset command. It is accepted only when the programming-voltage flag was already high when START was seen. It is armed by the STOP that follows, and it fires a one-cycle reset pulse for the chosen threshold once that flag has dropped again.

Top module: `cfg_supv_if`

## Requirements
- R1: After reset, `ctrl_o` equals the persistent reset value with both enable latches (bit 2, bit 1) and bit 3 at 0. `sda_low_o` is released (0), and `nv_commit_o` and `trip_rst_o` are 0.
- R2: The slave byte B2h (register write) and B3h (register read) are acknowledged. A0h is acknowledged only if `vprog_i` was high at START. Any other slave byte is not acknowledged. An acknowledge is `sda_low_o` = 1 during the ninth clock of a byte.
- R3: While `nv_busy_i` is high at the end of a slave byte, that slave byte is not acknowledged.
- R4: The address byte and the first data byte of an acknowledged write are acknowledged. A register write has effect only when the address byte is FFh.
- R5: Only the first data byte of a write is acknowledged and used. Later data bytes are not acknowledged, and the first byte still takes effect at STOP. A STOP in the middle of a byte aborts the transfer.
- R6: A register write with data bits [2:1] = 01 sets the write-enable latch (bit 1). A write with bits [2:1] = 11 sets the register-enable latch (bit 2), but only if bit 1 is already 1.
- R7: A register write with bits [2:1] = 00 while both latches are 1 loads bits 7, 6, 5, 4 and 0 from the data. It raises `nv_commit_o` in the cycle after the STOP event and clears both latches. The persistent bits change only with a commit.
- R8: A register write with bits [2:1] = 00 while either latch is 0 is still acknowledged, but it changes nothing and raises no commit.
- R9: A B3h read drives `ctrl_o` most significant bit first, with a 0 bit shown as `sda_low_o` = 1. The line is released for the master's acknowledge and afterwards. A new START may follow without a STOP.
- R10: An A0h write with address 03h or 0Bh and data 00h, ended by STOP, pulses `trip_rst_o` bit 0 (for 03h) or bit 1 (for 0Bh). The pulse comes one cycle after the first clock edge at which `vprog_i` is low. Any other data value gives no pulse.
- R11: `nv_commit_o` and `trip_rst_o` are single-cycle pulses, and at most one trip bit is high at a time.
- R12: Bit 3 of `ctrl_o` always reads 0, and bit 2 is never 1 while bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt_i | input | 1 | START condition seen (one cycle) |
| stop_evt_i | input | 1 | STOP condition seen (one cycle) |
| bit_evt_i | input | 1 | Clock rising edge seen, bit valid (one cycle) |
| bit_val_i | input | 1 | Data line value sampled with `bit_evt_i` |
| vprog_i | input | 1 | Programming-voltage present flag |
| nv_busy_i | input | 1 | Persistent store still writing |
| sda_low_o | output | 1 | Request to pull the data line low |
| ctrl_o | output | 8 | Configuration register contents |
| nv_commit_o | output | 1 | Pulse: store the persistent fields |
| trip_rst_o | output | 2 | Pulse per threshold: reset its trip level |

## Verification
The bound checker watches several properties on every cycle. It checks that both output pulses last one cycle and that at most one trip pulse is high. It checks that a commit only ever follows a STOP event, and that a trip pulse only follows a cycle with the programming flag low. It also checks that the persistent fields never move without a commit, that bit 3 stays 0, and that the register-enable latch is never set without the write-enable latch. Other behaviours need whole bus transactions, so only the bench scenarios can show them. These are acknowledge versus no-acknowledge per slave byte, busy and flag state, the three-step latch sequence and its refusals, the ignored wrong address, the extra-byte case, the read data order and restart, and which threshold fires.

// File: rtl/cfg_supv_pkg.sv
package cfg_supv_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;
  localparam int N_TRIP = 2;

  localparam logic [3:0] PRE_CFG = 4'b1011;
  localparam logic [BYTE_W-1:0] SLV_CFG_WR = 8'hB2;
  localparam logic [BYTE_W-1:0] SLV_CFG_RD = 8'hB3;
  localparam logic [BYTE_W-1:0] SLV_MEM_WR = 8'hA0;
  localparam logic [BYTE_W-1:0] CFG_ADDR   = 8'hFF;

  // threshold n sits at byte n of this vector
  localparam logic [N_TRIP*BYTE_W-1:0] TRIP_ADDRS = {8'h0B, 8'h03};

  // register field positions (decoded by neighbouring logic)
  localparam int CB_PU_HI = 7;
  localparam int CB_WD_HI = 6;
  localparam int CB_WD_LO = 5;
  localparam int CB_PROT  = 4;
  localparam int CB_RWE   = 2;
  localparam int CB_WE    = 1;
  localparam int CB_PU_LO = 0;

  localparam int NV_W = 5;

  typedef enum logic [2:0] {
    FR_IDLE, FR_SLV, FR_ADDR, FR_DATA, FR_RD, FR_SKIP
  } fr_state_e;

endpackage

// File: rtl/cfg_frame_track.sv
module cfg_frame_track
  import cfg_supv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bit_i,
  input  logic              bit_val_i,
  input  logic              vprog_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              sda_low_o,
  output logic              done_o,
  output logic              kind_cfg_o,
  output logic              hv_o,
  output logic [BYTE_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o
);

  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  fr_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic [1:0]        ndata_q, ndata_d;
  logic              kind_q, kind_d;
  logic              hv_q, hv_d;
  logic              ack_c;

  always_comb begin
    case (state_q)
      FR_SLV:  ack_c = !busy_i && (sh_q == SLV_CFG_WR || sh_q == SLV_CFG_RD ||
                                   (sh_q == SLV_MEM_WR && hv_q));
      FR_ADDR: ack_c = 1'b1;
      FR_DATA: ack_c = (ndata_q == 2'd0);
      default: ack_c = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    addr_d  = addr_q;
    data_d  = data_q;
    ndata_d = ndata_q;
    kind_d  = kind_q;
    hv_d    = hv_q;
    if (start_i) begin
      state_d = FR_SLV;
      cnt_d   = '0;
      ndata_d = '0;
      hv_d    = vprog_i;
    end else if (stop_i) begin
      state_d = FR_IDLE;
      cnt_d   = '0;
    end else if (bit_i && state_q != FR_IDLE) begin
      if (cnt_q != ACK_SLOT) begin
        sh_d  = {sh_q[BYTE_W-2:0], bit_val_i};
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
        case (state_q)
          FR_SLV: begin
            kind_d = (sh_q[BYTE_W-1:BYTE_W-4] == PRE_CFG);
            if (!ack_c)       state_d = FR_SKIP;
            else if (sh_q[0]) state_d = FR_RD;
            else              state_d = FR_ADDR;
          end
          FR_ADDR: begin
            addr_d  = sh_q;
            state_d = FR_DATA;
          end
          FR_DATA: begin
            if (ndata_q == 2'd0)  data_d  = sh_q;
            if (ndata_q != 2'd3)  ndata_d = ndata_q + 1'b1;
          end
          FR_RD:   state_d = FR_SKIP;
          default: state_d = state_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      ndata_q <= '0;
      kind_q  <= 1'b0;
      hv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      ndata_q <= ndata_d;
      kind_q  <= kind_d;
      hv_q    <= hv_d;
    end
  end

  assign sda_low_o = (cnt_q == ACK_SLOT && ack_c) ||
                     (state_q == FR_RD && cnt_q < ACK_SLOT &&
                      !rd_byte_i[3'd7 - cnt_q[2:0]]);
  assign done_o     = stop_i && state_q == FR_DATA && cnt_q == '0 && ndata_q != 2'd0;
  assign kind_cfg_o = kind_q;
  assign hv_o       = hv_q;
  assign addr_o     = addr_q;
  assign data_o     = data_q;

endmodule

// File: rtl/cfg_ctrl_store.sv
module cfg_ctrl_store
  import cfg_supv_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_RST = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              kind_cfg_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              commit_o
);

  logic [NV_W-1:0] nv_q, nv_d;
  logic            we_q, we_d;
  logic            rwe_q, rwe_d;
  logic            commit_q, commit_d;
  logic            hit;
  logic [1:0]      cmd;
  logic            unused_spare;

  assign hit          = done_i && kind_cfg_i && addr_i == CFG_ADDR;
  assign cmd          = {data_i[CB_RWE], data_i[CB_WE]};
  assign unused_spare = data_i[3];

  always_comb begin
    nv_d     = nv_q;
    we_d     = we_q;
    rwe_d    = rwe_q;
    commit_d = 1'b0;
    if (hit) begin
      case (cmd)
        2'b01: we_d = 1'b1;
        2'b11: if (we_q) rwe_d = 1'b1;
        2'b00: if (we_q && rwe_q) begin
          nv_d     = {data_i[CB_PU_HI], data_i[CB_WD_HI], data_i[CB_WD_LO],
                      data_i[CB_PROT], data_i[CB_PU_LO]};
          commit_d = 1'b1;
          we_d     = 1'b0;
          rwe_d    = 1'b0;
        end
        default: commit_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q     <= NV_RST;
      we_q     <= 1'b0;
      rwe_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      nv_q     <= nv_d;
      we_q     <= we_d;
      rwe_q    <= rwe_d;
      commit_q <= commit_d;
    end
  end

  always_comb begin
    ctrl_o           = '0;
    ctrl_o[CB_PU_HI] = nv_q[4];
    ctrl_o[CB_WD_HI] = nv_q[3];
    ctrl_o[CB_WD_LO] = nv_q[2];
    ctrl_o[CB_PROT]  = nv_q[1];
    ctrl_o[CB_PU_LO] = nv_q[0];
    ctrl_o[CB_RWE]   = rwe_q;
    ctrl_o[CB_WE]    = we_q;
  end
  assign commit_o = commit_q;

endmodule

// File: rtl/cfg_trip_seq.sv
module cfg_trip_seq
  import cfg_supv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              kind_cfg_i,
  input  logic              hv_i,
  input  logic [BYTE_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              vprog_i,
  output logic [N_TRIP-1:0] trip_o
);

  logic [N_TRIP-1:0] match;
  logic              arm;
  logic              pend_q, pend_d;
  logic [N_TRIP-1:0] sel_q, sel_d;
  logic [N_TRIP-1:0] pulse_q, pulse_d;

  for (genvar g = 0; g < N_TRIP; g++) begin : g_match
    assign match[g] = (addr_i == TRIP_ADDRS[g*BYTE_W +: BYTE_W]);
  end

  assign arm = done_i && !kind_cfg_i && hv_i && data_i == '0 && |match;

  always_comb begin
    pend_d  = pend_q;
    sel_d   = sel_q;
    pulse_d = '0;
    if (arm) begin
      pend_d = 1'b1;
      sel_d  = match;
    end else if (pend_q && !vprog_i) begin
      pend_d  = 1'b0;
      pulse_d = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      sel_q   <= '0;
      pulse_q <= '0;
    end else begin
      pend_q  <= pend_d;
      sel_q   <= sel_d;
      pulse_q <= pulse_d;
    end
  end

  assign trip_o = pulse_q;

endmodule

// File: rtl/cfg_supv_if.sv
module cfg_supv_if
  import cfg_supv_pkg::*;
#(
  parameter logic [NV_W-1:0] NV_RST = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt_i,
  input  logic              stop_evt_i,
  input  logic              bit_evt_i,
  input  logic              bit_val_i,
  input  logic              vprog_i,
  input  logic              nv_busy_i,
  output logic              sda_low_o,
  output logic [7:0]        ctrl_o,
  output logic              nv_commit_o,
  output logic [N_TRIP-1:0] trip_rst_o
);

  logic              done;
  logic              kind_cfg;
  logic              hv;
  logic [BYTE_W-1:0] addr;
  logic [BYTE_W-1:0] data;

  cfg_frame_track u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_evt_i),
    .stop_i     (stop_evt_i),
    .bit_i      (bit_evt_i),
    .bit_val_i  (bit_val_i),
    .vprog_i    (vprog_i),
    .busy_i     (nv_busy_i),
    .rd_byte_i  (ctrl_o),
    .sda_low_o  (sda_low_o),
    .done_o     (done),
    .kind_cfg_o (kind_cfg),
    .hv_o       (hv),
    .addr_o     (addr),
    .data_o     (data)
  );

  cfg_ctrl_store #(.NV_RST(NV_RST)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .kind_cfg_i (kind_cfg),
    .addr_i     (addr),
    .data_i     (data),
    .ctrl_o     (ctrl_o),
    .commit_o   (nv_commit_o)
  );

  cfg_trip_seq u_trip (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .kind_cfg_i (kind_cfg),
    .hv_i       (hv),
    .addr_i     (addr),
    .data_i     (data),
    .vprog_i    (vprog_i),
    .trip_o     (trip_rst_o)
  );

endmodule

// File: rtl/cfg_supv_if_chk.sv
module cfg_supv_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_evt_i,
  input logic       vprog_i,
  input logic [7:0] ctrl_o,
  input logic       nv_commit_o,
  input logic [1:0] trip_rst_o
);

  assert_commit_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit_o |=> !nv_commit_o);

  assert_trip_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_rst_o != 2'b00) |=> (trip_rst_o == 2'b00));

  assert_trip_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trip_rst_o));

  assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit_o |-> $past(stop_evt_i));

  assert_nv_moves_with_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ctrl_o[7:4], ctrl_o[0]}) |-> nv_commit_o);

  assert_trip_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_rst_o != 2'b00) |-> !$past(vprog_i));

  assert_rwe_needs_we_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_o[2] |-> ctrl_o[1]);

  assert_spare_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_o[3]);

endmodule

bind cfg_supv_if cfg_supv_if_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_evt_i  (stop_evt_i),
  .vprog_i     (vprog_i),
  .ctrl_o      (ctrl_o),
  .nv_commit_o (nv_commit_o),
  .trip_rst_o  (trip_rst_o)
);

// File: tb/cfg_supv_if_tb_top.sv
module cfg_supv_if_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_evt, stop_evt, bit_evt, bit_val, vprog, nv_busy;
  logic       sda_low;
  logic [7:0] ctrl;
  logic       nv_commit;
  logic [1:0] trip_rst;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];   // 0 = commit, 1 = trip bit0, 2 = trip bit1

  always #5 clk = ~clk;

  cfg_supv_if dut_i (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt), .stop_evt_i(stop_evt),
    .bit_evt_i(bit_evt), .bit_val_i(bit_val), .vprog_i(vprog), .nv_busy_i(nv_busy),
    .sda_low_o(sda_low), .ctrl_o(ctrl), .nv_commit_o(nv_commit), .trip_rst_o(trip_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1'b1;
    @(negedge clk) stop_evt = 1'b0;
  endtask

  task automatic clk_bit(input logic v);
    @(negedge clk) begin bit_evt = 1'b1; bit_val = v; end
    @(negedge clk) bit_evt = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) clk_bit(b[i]);
    chk(sda_low == exp_ack, req, sda_low, exp_ack);
    clk_bit(1'b1);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
    do_start();
    send_byte(8'hB2, 1'b1, "R2");
    send_byte(a, 1'b1, "R4");
    send_byte(d, 1'b1, "R4");
    do_stop();
  endtask

  task automatic trip_cmd(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk) vprog = 1'b1;
    do_start();
    send_byte(8'hA0, 1'b1, "R2");
    send_byte(a, 1'b1, "R4");
    send_byte(d, 1'b1, "R4");
    do_stop();
    repeat (3) @(negedge clk);
    chk(trip_rst == 2'b00, "R10", trip_rst, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (nv_commit) begin
        n_chk++;
        if (exp_q.size() == 0 || exp_q[0] != 0) begin
          n_fail++;
          $display("FAIL R7: got commit expected %0d", exp_q.size() == 0 ? -1 : exp_q[0]);
        end else void'(exp_q.pop_front());
      end
      for (int i = 0; i < 2; i++) begin
        if (trip_rst[i]) begin
          n_chk++;
          if (exp_q.size() == 0 || exp_q[0] != i + 1) begin
            n_fail++;
            $display("FAIL R10: got trip %0d expected %0d", i + 1,
                     exp_q.size() == 0 ? -1 : exp_q[0]);
          end else void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; start_evt = 0; stop_evt = 0; bit_evt = 0; bit_val = 0;
    vprog = 0; nv_busy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl == 8'h00, "R1", ctrl, 8'h00);
    chk(sda_low == 1'b0, "R1", sda_low, 0);
    chk(nv_commit == 1'b0 && trip_rst == 2'b00, "R1", {nv_commit, trip_rst}, 0);

    // R8 store without latches
    cfg_write(8'hFF, 8'hF1);
    @(negedge clk);
    chk(ctrl == 8'h00, "R8", ctrl, 8'h00);
    // R6 register-enable refused without write-enable
    cfg_write(8'hFF, 8'h06);
    chk(ctrl == 8'h00, "R6", ctrl, 8'h00);
    // R4 wrong address has no effect
    cfg_write(8'hFE, 8'h02);
    chk(ctrl == 8'h00, "R4", ctrl, 8'h00);
    // R6 latch sequence
    cfg_write(8'hFF, 8'h02);
    chk(ctrl == 8'h02, "R6", ctrl, 8'h02);
    cfg_write(8'hFF, 8'h06);
    chk(ctrl == 8'h06, "R6", ctrl, 8'h06);
    // R7 store
    exp_q.push_back(0);
    cfg_write(8'hFF, 8'hB1);
    chk(nv_commit == 1'b1, "R7", nv_commit, 1);
    chk(ctrl == 8'hB1, "R7", ctrl, 8'hB1);
    @(negedge clk);
    chk(nv_commit == 1'b0, "R11", nv_commit, 0);

    // R9 read, then restart without STOP
    do_start();
    send_byte(8'hB3, 1'b1, "R2");
    rd = '0;
    for (int i = 7; i >= 0; i--) begin
      rd[i] = !sda_low;
      clk_bit(1'b1);
    end
    chk(rd == 8'hB1, "R9", rd, 8'hB1);
    chk(sda_low == 1'b0, "R9", sda_low, 0);
    clk_bit(1'b1);
    clk_bit(1'b0);
    chk(sda_low == 1'b0, "R9", sda_low, 0);
    cfg_write(8'hFF, 8'h02);
    chk(ctrl == 8'hB3, "R9", ctrl, 8'hB3);

    // R5 extra data byte
    cfg_write(8'hFF, 8'h06);
    exp_q.push_back(0);
    do_start();
    send_byte(8'hB2, 1'b1, "R2");
    send_byte(8'hFF, 1'b1, "R4");
    send_byte(8'h60, 1'b1, "R5");
    send_byte(8'hFF, 1'b0, "R5");
    do_stop();
    @(negedge clk);
    chk(ctrl == 8'h60, "R5", ctrl, 8'h60);

    // R3 busy blocks
    nv_busy = 1'b1;
    do_start();
    send_byte(8'hB2, 1'b0, "R3");
    do_stop();
    nv_busy = 1'b0;

    // R2 unknown slave and A0 without programming flag
    do_start();
    send_byte(8'h90, 1'b0, "R2");
    do_stop();
    do_start();
    send_byte(8'hA0, 1'b0, "R2");
    do_stop();

    // R10 threshold resets
    trip_cmd(8'h03, 8'h00);
    exp_q.push_back(1);
    @(negedge clk) vprog = 1'b0;
    @(negedge clk);
    chk(trip_rst == 2'b01, "R10", trip_rst, 1);
    @(negedge clk);
    chk(trip_rst == 2'b00, "R11", trip_rst, 0);

    trip_cmd(8'h0B, 8'h00);
    exp_q.push_back(2);
    @(negedge clk) vprog = 1'b0;
    @(negedge clk);
    chk(trip_rst == 2'b10, "R10", trip_rst, 2);

    trip_cmd(8'h03, 8'h01);
    @(negedge clk) vprog = 1'b0;
    repeat (3) @(negedge clk);
    chk(trip_rst == 2'b00, "R10", trip_rst, 0);
    chk(ctrl[3] == 1'b0, "R12", ctrl[3], 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule